// File: doc/BRIEF.md
# Logarithmic-Domain PI Receiver Gain Controller

This block closes a receiver gain loop in decibels. Each time an upstream power estimator pulses its strobe, the block does four things. It maps the linear power estimate, on a 1..225 scale, to half-decibel units through a computed table. It subtracts that value from a reference level held in a register. It runs a proportional-integral law on the difference, with shift-amount gains. It then turns the resulting total gain into two amplifier controls. One is a two-state low-noise amplifier, with steps of 0 dB and +20 dB. The other is a variable-gain code in 0.5 dB steps, covering 0 to 30 dB.

Because the loop works on logarithms, a saturated estimator gives an asymmetric error range. With the reference at 31 (35 on the power scale), the error is at most +31 at the weak end and at least −16 at the strong end. The block keeps this asymmetry. When the amplifier mode flips, the variable-gain code moves by the full amplifier step in the opposite direction, so the total gain has no jump. In normal use, the strobe comes about ten times per 2560-chip slot.

Top module: `agc_log_pi`

## Requirements
- R1: The measured level is round(20·log10(P)) in half-dB units. P is est_pow clamped to 1..225: a value of 0 counts as 1, and anything above 225 counts as 225.
- R2: The error is ref_hdb minus the measured level, as a signed value. With ref_hdb = 31 it lies between −16 and +31.
- R3: For each strobe, the total is sat(I + floor(e / 2^kp_sh)) and the new integrator is sat(I + floor(e / 2^ki_sh)). I is the integrator value before this strobe, and sat clamps to 0..100. The integrator starts at 0.
- R4: ref_hdb, kp_sh, ki_sh and est_pow are sampled on the clock edge that sees est_vld high. Later changes to these inputs do not affect that update.
- R5: upd is high for exactly one cycle per strobe. It appears after the third rising edge that follows the drive of est_vld (a latency of three cycles), and back-to-back strobes give back-to-back pulses.
- R6: lna_hi and vga_code change only in a cycle where upd is high.
- R7: lna_hi rises when the total is above 60. It falls when the total is below 54, which gives 3 dB of hysteresis. Otherwise it holds.
- R8: vga_code + 40·lna_hi equals the total. vga_code always lies in 0..60, so a mode change moves vga_code by 40 the opposite way.
- R9: Reset, which is synchronous and active high, clears upd, lna_hi, vga_code and the integrator to 0.
- R10: Cycles without est_vld leave the outputs and the loop state untouched, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| est_vld | input | 1 | One-cycle strobe marking a new power estimate |
| est_pow | input | 8 | Linear power estimate, meaningful range 1..225 |
| ref_hdb | input | 8 | Reference level in half-dB units (31 corresponds to power 35) |
| kp_sh | input | 3 | Proportional gain as a right-shift amount |
| ki_sh | input | 3 | Integral gain as a right-shift amount |
| lna_hi | output | 1 | Low-noise amplifier mode: 0 = 0 dB, 1 = +20 dB |
| vga_code | output | 6 | Variable-gain code in 0.5 dB steps, 0..60 |
| upd | output | 1 | One-cycle pulse marking new gain outputs |

## Verification
The hardest case to reach is the low-noise amplifier dropping out of its high mode. That requires the total to sit inside the 54..60 band for one update while the mode holds, and then fall below 54 on the next. The stimulus first drives the integrator into saturation with weak-signal strobes. It then applies strong-signal strobes with a gain chosen so that the total falls by exactly 8 half-dB per update, which lands it on 60 and then on 52. This exercises both the hold within the band and the downward switch. A long run of randomly spaced, often back-to-back strobes with changing reference and gains follows. A behavioural model compares every cycle of that run.

// File: rtl/agc_pkg.sv
package agc_pkg;

  // half-dB value of a linear power level, rounded to nearest
  function automatic int hdb_of(input int p);
    return $rtoi(20.0 * $log10(real'(p)) + 0.5);
  endfunction

  typedef enum logic {LNA_LOW = 1'b0, LNA_HIGH = 1'b1} lna_mode_e;

endpackage

// File: rtl/agc_db_rom.sv
module agc_db_rom #(
  parameter int DEPTH = 225,
  parameter int AW    = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  output logic [DW-1:0] q
);
  logic [DW-1:0] mem [DEPTH];

  // table entry i holds the level of power i+1
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DW'(agc_pkg::hdb_of(i + 1));
  end

  // registered read, no reset, so the table maps to block RAM
  always_ff @(posedge clk) begin
    if (rd_en) q <= mem[addr];
  end
endmodule

// File: rtl/agc_pi_core.sv
module agc_pi_core #(
  parameter int DBW     = 8,
  parameter int SHW     = 3,
  parameter int TOT_MAX = 100,
  parameter int GW      = 7
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           v_in,
  input  logic [DBW-1:0] lvl,
  input  logic [DBW-1:0] ref_lvl,
  input  logic [SHW-1:0] kp_sh,
  input  logic [SHW-1:0] ki_sh,
  output logic           v_out,
  output logic [GW-1:0]  tot_q
);
  localparam int XW = ((DBW > GW) ? DBW : GW) + 3;

  logic [GW-1:0]        integ_q;
  logic signed [XW-1:0] err, p_term, i_term, tot_x, int_x;

  function automatic logic [GW-1:0] clamp(input logic signed [XW-1:0] x);
    if (x < 0) return '0;
    else if (x > $signed(XW'(TOT_MAX))) return GW'(TOT_MAX);
    else return x[GW-1:0];
  endfunction

  always_comb begin
    err    = $signed({{(XW-DBW){1'b0}}, ref_lvl}) - $signed({{(XW-DBW){1'b0}}, lvl});
    p_term = err >>> kp_sh;
    i_term = err >>> ki_sh;
    tot_x  = $signed({{(XW-GW){1'b0}}, integ_q}) + p_term;
    int_x  = $signed({{(XW-GW){1'b0}}, integ_q}) + i_term;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v_out   <= 1'b0;
      tot_q   <= '0;
      integ_q <= '0;
    end else begin
      v_out <= v_in;
      if (v_in) begin
        tot_q   <= clamp(tot_x);
        integ_q <= clamp(int_x);
      end
    end
  end
endmodule

// File: rtl/agc_gain_split.sv
module agc_gain_split #(
  parameter int GW    = 7,
  parameter int VW    = 6,
  parameter int VMAX  = 60,
  parameter int STEP  = 40,
  parameter int HYST  = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          v_in,
  input  logic [GW-1:0] tot,
  output logic          lna_hi,
  output logic [VW-1:0] vga_code,
  output logic          upd
);
  import agc_pkg::*;

  lna_mode_e     mode_q, mode_n;
  logic [GW-1:0] vga_n;

  always_comb begin
    mode_n = mode_q;
    if (mode_q == LNA_LOW && tot > GW'(VMAX))
      mode_n = LNA_HIGH;
    else if (mode_q == LNA_HIGH && tot < GW'(VMAX - HYST))
      mode_n = LNA_LOW;
    vga_n = (mode_n == LNA_HIGH) ? tot - GW'(STEP) : tot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= LNA_LOW;
      vga_code <= '0;
      upd      <= 1'b0;
    end else begin
      upd <= v_in;
      if (v_in) begin
        mode_q   <= mode_n;
        vga_code <= vga_n[VW-1:0];
      end
    end
  end

  assign lna_hi = (mode_q == LNA_HIGH);
endmodule

// File: rtl/agc_log_pi.sv
module agc_log_pi #(
  parameter int PW       = 8,
  parameter int PMAX     = 225,
  parameter int DBW      = 8,
  parameter int SHW      = 3,
  parameter int VGA_MAX  = 60,
  parameter int LNA_STEP = 40,
  parameter int HYST     = 6
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           est_vld,
  input  logic [PW-1:0]                  est_pow,
  input  logic [DBW-1:0]                 ref_hdb,
  input  logic [SHW-1:0]                 kp_sh,
  input  logic [SHW-1:0]                 ki_sh,
  output logic                           lna_hi,
  output logic [$clog2(VGA_MAX+1)-1:0]   vga_code,
  output logic                           upd
);
  localparam int TOT_MAX = VGA_MAX + LNA_STEP;
  localparam int GW      = $clog2(TOT_MAX + 1);
  localparam int VW      = $clog2(VGA_MAX + 1);

  logic [PW-1:0]  pow_c, rom_addr;
  logic [DBW-1:0] lvl, ref1;
  logic [SHW-1:0] kp1, ki1;
  logic           v1, v2;
  logic [GW-1:0]  tot_w;

  // clamp the estimate onto the table range
  always_comb begin
    if (est_pow == '0)             pow_c = PW'(1);
    else if (est_pow > PW'(PMAX))  pow_c = PW'(PMAX);
    else                           pow_c = est_pow;
    rom_addr = pow_c - PW'(1);
  end

  agc_db_rom #(.DEPTH(PMAX), .AW(PW), .DW(DBW)) u_rom (
    .clk(clk), .rd_en(est_vld), .addr(rom_addr), .q(lvl)
  );

  // loop settings travel with the estimate
  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      ref1 <= '0;
      kp1  <= '0;
      ki1  <= '0;
    end else begin
      v1 <= est_vld;
      if (est_vld) begin
        ref1 <= ref_hdb;
        kp1  <= kp_sh;
        ki1  <= ki_sh;
      end
    end
  end

  agc_pi_core #(.DBW(DBW), .SHW(SHW), .TOT_MAX(TOT_MAX), .GW(GW)) u_pi (
    .clk(clk), .rst(rst), .v_in(v1), .lvl(lvl), .ref_lvl(ref1),
    .kp_sh(kp1), .ki_sh(ki1), .v_out(v2), .tot_q(tot_w)
  );

  agc_gain_split #(.GW(GW), .VW(VW), .VMAX(VGA_MAX), .STEP(LNA_STEP), .HYST(HYST)) u_split (
    .clk(clk), .rst(rst), .v_in(v2), .tot(tot_w),
    .lna_hi(lna_hi), .vga_code(vga_code), .upd(upd)
  );
endmodule

// File: rtl/agc_log_pi_chk.sv
module agc_log_pi_chk #(
  parameter int GW   = 7,
  parameter int VW   = 6,
  parameter int VMAX = 60,
  parameter int STEP = 40,
  parameter int HYST = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          est_vld,
  input logic          upd,
  input logic          lna_hi,
  input logic [VW-1:0] vga_code,
  input logic [GW-1:0] tot
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;
  end

  // R5
  upd_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (upd == $past(est_vld, 3)));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && !upd) |-> ($stable(lna_hi) && $stable(vga_code)));

  // R8
  vga_range_chk: assert property (@(posedge clk) disable iff (rst)
    int'(vga_code) <= VMAX);

  // R8
  gain_sum_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && upd) |-> (int'(vga_code) + (lna_hi ? STEP : 0) == int'($past(tot))));

  // R7
  lna_up_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $rose(lna_hi)) |-> (int'($past(tot)) > VMAX));

  // R7
  lna_down_chk: assert property (@(posedge clk) disable iff (rst)
    (age != 2'd0 && $fell(lna_hi)) |-> (int'($past(tot)) < VMAX - HYST));
endmodule

bind agc_log_pi agc_log_pi_chk #(
  .GW(GW), .VW(VW), .VMAX(VGA_MAX), .STEP(LNA_STEP), .HYST(HYST)
) u_chk (
  .clk(clk), .rst(rst), .est_vld(est_vld), .upd(upd),
  .lna_hi(lna_hi), .vga_code(vga_code), .tot(tot_w)
);

// File: tb/agc_log_pi_bench.sv
module agc_log_pi_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       est_vld = 1'b0;
  logic [7:0] est_pow = 8'd0;
  logic [7:0] ref_hdb = 8'd31;
  logic [2:0] kp_sh = 3'd0;
  logic [2:0] ki_sh = 3'd0;
  logic       lna_hi, upd;
  logic [5:0] vga_code;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  agc_log_pi u_agc_log_pi (
    .clk(clk), .rst(rst), .est_vld(est_vld), .est_pow(est_pow),
    .ref_hdb(ref_hdb), .kp_sh(kp_sh), .ki_sh(ki_sh),
    .lna_hi(lna_hi), .vga_code(vga_code), .upd(upd)
  );

  // ---------------- behavioural reference model ----------------
  int m_int, m_lna;
  int p0_v, p0_l, p0_g, p1_v, p1_l, p1_g;
  int exp_u, exp_l, exp_g;

  function automatic int lvl_of(input int p);
    int pc;
    pc = (p < 1) ? 1 : (p > 225 ? 225 : p);
    return int'($floor(20.0 * $log10(real'(pc)) + 0.5));
  endfunction

  function automatic int fdiv(input int e, input int sh);
    return int'($floor(real'(e) / real'(1 << sh)));
  endfunction

  function automatic int sat(input int x);
    return (x < 0) ? 0 : (x > 100 ? 100 : x);
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_int = 0; m_lna = 0;
      p0_v = 0; p1_v = 0; p0_l = 0; p1_l = 0; p0_g = 0; p1_g = 0;
      exp_u = 0; exp_l = 0; exp_g = 0;
    end else begin
      int e, t;
      exp_u = p1_v;
      if (p1_v != 0) begin exp_l = p1_l; exp_g = p1_g; end
      p1_v = p0_v; p1_l = p0_l; p1_g = p0_g;
      p0_v = 0;
      if (est_vld) begin
        e = int'(ref_hdb) - lvl_of(int'(est_pow));
        t = sat(m_int + fdiv(e, int'(kp_sh)));
        m_int = sat(m_int + fdiv(e, int'(ki_sh)));
        if (m_lna == 0 && t > 60) m_lna = 1;
        else if (m_lna == 1 && t < 54) m_lna = 0;
        p0_v = 1; p0_l = m_lna; p0_g = t - 40 * m_lna;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      chk(int'(upd) == exp_u, "R5 upd", int'(upd), exp_u);
      chk(int'(lna_hi) == exp_l, "R7 lna_hi", int'(lna_hi), exp_l);
      chk(int'(vga_code) == exp_g, "R8 vga_code", int'(vga_code), exp_g);
      chk(vga_code <= 6'd60, "R8 range", int'(vga_code), 60);
    end
  end

  task automatic strobe(input int p);
    @(negedge clk);
    est_vld = 1'b1; est_pow = 8'(p);
    @(negedge clk);
    est_vld = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic expect_out(input int l, input int g, input string tag);
    chk(int'(lna_hi) == l, tag, int'(lna_hi), l);
    chk(int'(vga_code) == g, tag, int'(vga_code), g);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    chk(upd == 1'b0, "R9 upd", int'(upd), 0);
    expect_out(0, 0, "R9 outputs");

    // R1 low clamp, R2 error sign: P=0 taken as 1, e=31, total=31
    ref_hdb = 8'd31; kp_sh = 3'd0; ki_sh = 3'd7;
    strobe(0);
    expect_out(0, 31, "R1 zero clamp");

    // R1 high clamp: 255 and 225 both give level 47, e=13
    ref_hdb = 8'd60;
    strobe(255);
    expect_out(0, 13, "R1 high clamp");
    strobe(225);
    expect_out(0, 13, "R1 at 225");

    // R3 integrator delay: integrator takes e=31 after this update
    ref_hdb = 8'd31; kp_sh = 3'd7; ki_sh = 3'd0;
    strobe(1);
    expect_out(0, 0, "R3 delayed integral");
    strobe(35);
    expect_out(0, 31, "R3 integral applied");

    // R3 saturation at 100, R7 up
    kp_sh = 3'd1; ki_sh = 3'd1;
    for (int i = 0; i < 12; i++) strobe(1);
    expect_out(1, 60, "R3 upper saturation");

    // R3 anti-windup: first negative step acts immediately
    strobe(225);
    expect_out(1, 52, "R3 no windup");

    // R7 hold inside band, then drop below 54
    for (int i = 0; i < 4; i++) strobe(225);
    expect_out(1, 20, "R7 hold in band");
    strobe(225);
    expect_out(0, 52, "R7 fall R8 opposite move");

    // R7 rise: total 67
    strobe(1);
    expect_out(1, 27, "R7 rise");

    // R10 inputs ignored without strobe
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      est_pow = 8'($urandom_range(0, 255));
      ref_hdb = 8'($urandom_range(0, 63));
      kp_sh = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    expect_out(1, 27, "R10 no strobe");

    // R4 R5 random, often back-to-back strobes with changing settings
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      est_vld = ($urandom_range(0, 2) != 0);
      est_pow = 8'($urandom_range(0, 255));
      ref_hdb = 8'($urandom_range(0, 63));
      kp_sh = 3'($urandom_range(0, 7));
      ki_sh = 3'($urandom_range(0, 7));
    end
    @(negedge clk);
    est_vld = 1'b0;
    repeat (5) @(negedge clk);

    // R9 reset in the middle of activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    expect_out(0, 0, "R9 reset again");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule